// File: doc/BRIEF.md
# UART Receive Address-Match Filter

This block sits between the character output of a UART receiver and the receive data buffer. On a multidrop line, it decides which received characters reach the buffer. A character whose most significant bit is set is an address character. When filtering is active, each address character is compared against two programmable match values. Each match value has its own enable. The outcome of that comparison decides whether the address character is kept. It also decides whether the data characters that follow it are kept, up to the next address character.

Software programs the two match values and the two enables through a small register port. Both the port and the values can be read back at any time. When a smart-card mode input is high, the enables are overridden and every character is forwarded. Each accepted character leaves the block one clock later as a single-cycle valid pulse with registered data.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset, both match values and the control word read back as 0, `out_valid` is low, and the session state is "no match".
- R2: Register select 0 holds match value A and select 1 holds match value B. Select 2 is the control word, with the enable for A in its most significant bit (bit 7 at the default width) and the enable for B in the bit below it (bit 6). Its other bits read 0, and select 3 reads 0. Reads are combinational, and a write takes effect on the clock edge where `cfg_wr_en` is high.
- R3: With both enables clear and smart-card mode low, every received character is forwarded unchanged.
- R4: With `smartcard_mode` high, every received character is forwarded whatever the enables are, and the session state is left unchanged.
- R5: When filtering is active (at least one enable set, smart-card mode low), a character with its most significant bit set is forwarded only if it equals an enabled match value. With both enables set, equality with either value suffices.
- R6: When filtering is active, a character with its most significant bit clear is forwarded only if the most recent filtered address character matched. Before any such address character has arrived, it is dropped.
- R7: For each accepted input character, `out_valid` is high for exactly the one cycle after the `rx_valid` cycle, and `out_data` carries that character in the same cycle. `out_valid` is low in every other cycle.
- R8: A new match value is used from the next address character on. Writing a match value or an enable does not re-evaluate the current session state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_sel` |
| smartcard_mode | input | 1 | Forces pass-through when high |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| out_valid | output | 1 | Forwarded character strobe |
| out_data | output | DATA_W | Forwarded character |

## Verification
The bench builds the block with `DATA_W = 4`. This shrinks the character space to sixteen codes, eight of which are address codes. At that size the bench can sweep every pair of match values, every enable combination and both smart-card settings, and send all sixteen characters under each configuration. An arithmetic model carries the session state across the whole sweep. Directed sequences then cover reset readback, the control-word bit layout, the reset-time "no match" state, and a match value rewritten in the middle of a session.

// File: rtl/uart_addr_filter_pkg.sv
// Shared definitions for the receive address-match filter.
// Assumes two match channels; channel 0 is "A", channel 1 is "B".
package uart_addr_filter_pkg;

    localparam int NUM_MATCH = 2;
    localparam int SEL_W     = 2;

    // Register select codes seen on cfg_sel.
    typedef enum logic [SEL_W-1:0] {
        SEL_MATCH_A = 2'd0,
        SEL_MATCH_B = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/uaf_cfg_regs.sv
// Configuration registers: two match values and two enables.
// Control word: enable A in bit DATA_W-1, enable B in bit DATA_W-2,
// remaining bits read zero. Assumes DATA_W >= 3.
module uaf_cfg_regs
    import uart_addr_filter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr_en,
    input  logic [SEL_W-1:0]                   cfg_sel,
    input  logic [DATA_W-1:0]                  cfg_wdata,
    output logic [DATA_W-1:0]                  cfg_rdata,
    output logic [NUM_MATCH-1:0][DATA_W-1:0]   match_vals,
    output logic [NUM_MATCH-1:0]               match_en
);

    localparam int EN_A_BIT = DATA_W - 1;
    localparam int EN_B_BIT = DATA_W - 2;
    localparam int PAD_W    = DATA_W - 2;

    logic wr_a, wr_b, wr_ctrl;

    // Decode the write strobe per register.
    always_comb begin
        wr_a    = cfg_wr_en && (cfg_sel_e'(cfg_sel) == SEL_MATCH_A);
        wr_b    = cfg_wr_en && (cfg_sel_e'(cfg_sel) == SEL_MATCH_B);
        wr_ctrl = cfg_wr_en && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
    end

    // Hold match value A.
    always_ff @(posedge clk) begin
        if (!rst_n)    match_vals[0] <= '0;
        else if (wr_a) match_vals[0] <= cfg_wdata;
    end

    // Hold match value B.
    always_ff @(posedge clk) begin
        if (!rst_n)    match_vals[1] <= '0;
        else if (wr_b) match_vals[1] <= cfg_wdata;
    end

    // Hold the two enable bits of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_en <= '0;
        end else if (wr_ctrl) begin
            match_en[0] <= cfg_wdata[EN_A_BIT];
            match_en[1] <= cfg_wdata[EN_B_BIT];
        end
    end

    // Return the selected register.
    always_comb begin
        unique case (cfg_sel_e'(cfg_sel))
            SEL_MATCH_A: cfg_rdata = match_vals[0];
            SEL_MATCH_B: cfg_rdata = match_vals[1];
            SEL_CTRL:    cfg_rdata = {match_en[0], match_en[1], {PAD_W{1'b0}}};
            default:     cfg_rdata = '0;
        endcase
    end

    // R2: match values change only on a write strobe.
    assert_match_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(match_vals));

    // R2: enables change only on a write strobe.
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(match_en));

endmodule

// File: rtl/uaf_addr_cmp.sv
// Compares a character against every enabled match value.
// Purely combinational; the caller decides whether the character is an address.
module uaf_addr_cmp
    import uart_addr_filter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]                  char_in,
    input  logic [NUM_MATCH-1:0][DATA_W-1:0]   match_vals,
    input  logic [NUM_MATCH-1:0]               match_en,
    output logic                               hit
);

    logic [NUM_MATCH-1:0] hit_vec;

    // One equality comparator per match channel.
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chan
        assign hit_vec[i] = match_en[i] && (char_in == match_vals[i]);
    end

    // Any enabled channel that matches accepts the character.
    assign hit = |hit_vec;

endmodule

// File: rtl/uaf_gate.sv
// Forwarding gate with session state. Address characters (MSB set) reload
// the session flag while filtering; data characters follow the flag.
// Accepted characters are registered into a one-cycle output pulse.
module uaf_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filter_on,
    input  logic              hit,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int MSB = DATA_W - 1;

    logic is_addr;
    logic session_ok;
    logic accept;

    // Classify the character and decide whether it passes.
    always_comb begin
        is_addr = rx_data[MSB];
        if (!filter_on) accept = 1'b1;
        else if (is_addr) accept = hit;
        else accept = session_ok;
    end

    // Session flag: reloaded by each filtered address character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            session_ok <= 1'b0;
        else if (rx_valid && filter_on && is_addr)
            session_ok <= hit;
    end

    // Output register: one pulse per accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rx_valid && accept;
            if (rx_valid && accept) out_data <= rx_data;
        end
    end

    // R7: a pulse is always caused by an input strobe one cycle earlier.
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rx_valid));

    // R7: forwarded data is the character received one cycle earlier.
    assert_data_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(rx_data)));

    // R3 and R4: without filtering every character comes out.
    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !filter_on) |=> out_valid);

    // R5: a filtered address character passes exactly when the comparator hits.
    assert_addr_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filter_on && is_addr) |=> (out_valid == $past(hit)));

    // R6: data after a failed or absent address match is dropped.
    assert_drop_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filter_on && !is_addr && !session_ok) |=> !out_valid);

    // R8: the session flag moves only on a filtered address character.
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && filter_on && is_addr) |=> $stable(session_ok));

endmodule

// File: rtl/uart_addr_filter.sv
// Receive address-match filter for multidrop UART links.
// Assumes one character per rx_valid strobe and DATA_W >= 3.
// smartcard_mode high forces pass-through and freezes the session flag.
module uart_addr_filter
    import uart_addr_filter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              smartcard_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [NUM_MATCH-1:0][DATA_W-1:0] match_vals;
    logic [NUM_MATCH-1:0]             match_en;
    logic                             hit;
    logic                             filter_on;

    // Filtering is active when any enable is set and smart-card mode is off.
    assign filter_on = (|match_en) && !smartcard_mode;

    uaf_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .match_vals (match_vals),
        .match_en   (match_en)
    );

    uaf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .char_in    (rx_data),
        .match_vals (match_vals),
        .match_en   (match_en),
        .hit        (hit)
    );

    uaf_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .filter_on  (filter_on),
        .hit        (hit),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // R1: the output strobe is low in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/uart_addr_filter_tb.sv
`timescale 1ns/1ps
module uart_addr_filter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [1:0]   cfg_sel = 2'd0;
    logic [W-1:0] cfg_wdata = '0;
    logic [W-1:0] cfg_rdata;
    logic         smartcard_mode = 1'b0;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the configuration and session state.
    logic [W-1:0] m_a = '0, m_b = '0;
    bit m_ena = 0, m_enb = 0, m_flag = 0;

    always #4 clk = ~clk;

    uart_addr_filter #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .smartcard_mode(smartcard_mode), .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel == 2'd0) m_a = d;
        if (sel == 2'd1) m_b = d;
        if (sel == 2'd2) begin m_ena = d[W-1]; m_enb = d[W-2]; end
    endtask

    task automatic cfg_read(input logic [1:0] sel, input int exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    // Send one character and check the pulse one cycle later.
    task automatic send(input logic [W-1:0] c, input bit sc);
        bit filt, is_a, hit, exp_v;
        string tag;
        filt  = (m_ena || m_enb) && !sc;
        is_a  = c[W-1];
        hit   = (m_ena && c == m_a) || (m_enb && c == m_b);
        exp_v = !filt || (is_a ? hit : m_flag);
        if (filt && is_a) m_flag = hit;
        tag = sc ? "R4" : (!(m_ena || m_enb) ? "R3" : (is_a ? "R5" : "R6"));
        @(negedge clk);
        check(out_valid == 1'b0, "R7 idle", out_valid, 0);
        rx_valid = 1'b1; rx_data = c; smartcard_mode = sc;
        @(negedge clk);
        rx_valid = 1'b0;
        check(out_valid == exp_v, tag, out_valid, exp_v);
        if (exp_v) check(out_data == c, "R7 data", out_data, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(out_valid == 1'b0, "R1", out_valid, 0);
        cfg_read(2'd0, 0, "R1");
        cfg_read(2'd1, 0, "R1");
        cfg_read(2'd2, 0, "R1");
        // R2 map and layout
        cfg_write(2'd0, 4'd9);
        cfg_write(2'd1, 4'd12);
        cfg_write(2'd2, 4'b1111);
        cfg_read(2'd0, 9, "R2");
        cfg_read(2'd1, 12, "R2");
        cfg_read(2'd2, 4'b1100, "R2");
        cfg_read(2'd3, 0, "R2");
        cfg_write(2'd2, 4'b0100);
        cfg_read(2'd2, 4'b0100, "R2");
        cfg_write(2'd2, 4'b1000);
        // R6: no match after reset, data dropped
        send(4'd1, 0);
        // R5 then R6 / R8 sequence
        send(4'd9, 0);
        send(4'd3, 0);
        cfg_write(2'd0, 4'd10);
        cfg_read(2'd0, 10, "R8");
        send(4'd3, 0);   // R8: flag not re-evaluated
        send(4'd9, 0);   // R8: new value now in use
        send(4'd2, 0);
        send(4'd10, 0);
        send(4'd5, 0);
        // R4: smart-card forwards and leaves the flag alone
        send(4'd11, 1);
        send(4'd2, 1);
        send(4'd6, 0);
        // Exhaustive sweep
        for (int sc = 0; sc < 2; sc++)
            for (int en = 0; en < 4; en++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        cfg_write(2'd0, W'(a));
                        cfg_write(2'd1, W'(b));
                        cfg_write(2'd2, W'(en << (W - 2)));
                        for (int c = 0; c < 16; c++)
                            send(W'((c * 5 + a) % 16), bit'(sc));
                    end
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule